// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This unit keeps three 256-entry bit sets for every interrupt vector: waiting requests, vectors under service, and the trigger kind of each one. Requests arrive one at a time on an accept port. A core-facing pair of outputs shows whether an interrupt may be taken and which vector it is. The core takes the interrupt with an acknowledge strobe and later ends it with an end-of-interrupt strobe.

The unit folds the task priority and the highest class under service into a processor priority. A waiting vector is offered only when its class is strictly above that priority. When an end-of-interrupt retires a vector that came in level-triggered, the unit emits a one-cycle broadcast carrying that vector, so that the source can re-arm.

The vector class is bits [7:4] of the vector. Each vector set is stored as words of 32 bits; vector v is at word v/32, bit v mod 32. The highest-set search works through the sets in that word order.

Top module: `irq_prio_unit`

## Requirements
- R1: After a synchronous reset all three vector sets and the task priority are zero, so `irq_req_o`, `ppr_o` and `eoi_bc_o` read 0.
- R2: An accepted request whose kind code is 0 (fixed) or 1 (lowest priority) sets the vector's pending bit. Every other kind code (2 to 7) is dropped.
- R3: A request arriving while `glob_en_i` or `sw_en_i` is 0 is dropped.
- R4: `irq_req_o` is 1 only while both enables are 1 and (highest pending vector AND 0xF0) is strictly greater than the processor priority. `irq_vec_o` is then the highest pending vector. Both outputs are registered and follow a state change one cycle later.
- R5: The processor priority is the 8-bit task priority when its bits [7:4] are at least bits [7:4] of the highest in-service vector, and is otherwise (that vector AND 0xF0). An empty in-service set counts as vector 0.
- R6: A task-priority write keeps only bits [7:0] of the write data.
- R7: An acknowledge while `irq_req_o` is 1 sets the offered vector's in-service bit and clears its pending bit, and `irq_req_o` reads 0 in the cycle after. An acknowledge while `irq_req_o` is 0 changes nothing.
- R8: An end-of-interrupt clears the highest in-service bit. With the in-service set empty it changes nothing.
- R9: An accepted level request (`acc_level_i`=1) sets the vector's trigger bit, and an accepted edge request clears it. A level request for a vector that is already pending is dropped and leaves the trigger bit as it was.
- R10: An end-of-interrupt that retires a vector with its trigger bit set clears that bit and raises `eoi_bc_o` for one cycle, one cycle after the strobe, with the vector on `eoi_bc_vec_o`.
- R11: When accept, acknowledge and end-of-interrupt arrive in the same cycle, they take effect in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| glob_en_i | input | 1 | Global enable |
| sw_en_i | input | 1 | Software enable |
| acc_valid_i | input | 1 | Request strobe |
| acc_vec_i | input | 8 | Requested vector |
| acc_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_kind_i | input | 3 | Delivery kind; 0 fixed, 1 lowest priority, others dropped |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 32 | Task-priority write data; bits [7:0] are kept |
| ack_i | input | 1 | Core acknowledges the offered vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_req_o | output | 1 | An eligible interrupt is offered |
| irq_vec_o | output | 8 | Offered vector |
| ppr_o | output | 8 | Processor priority |
| eoi_bc_o | output | 1 | End-of-interrupt broadcast for a level vector |
| eoi_bc_vec_o | output | 8 | Vector of the broadcast |

## Verification
The bench drives the priority comparison at its boundaries: a pending class equal to the task priority, one just above it, and a task priority carrying stray upper write bits. A strict-versus-inclusive slip, or a missing truncation, would then offer an interrupt that must stay hidden. It exercises the trigger-bit rules through the broadcast alone: a level duplicate of an edge vector, an edge request that follows a level one, and an end-of-interrupt with nothing in service. A design that updated or kept the trigger bit wrongly would emit a broadcast the scoreboard does not expect. A single cycle carrying accept, acknowledge and end-of-interrupt together checks the ordering rule. There, retiring the wrong vector, or losing the fresh level request, shows up as a wrong broadcast vector or a wrong next offer. An acknowledge while nothing is offered, and the one-cycle drop of the request after an acknowledge, guard against a double take.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam logic [2:0] KIND_FIXED  = 3'd0;
  localparam logic [2:0] KIND_LOWEST = 3'd1;

  function automatic logic kind_is_fixed_like(input logic [2:0] kind);
    return (kind == KIND_FIXED) || (kind == KIND_LOWEST);
  endfunction
endpackage

// File: rtl/irq_prio_find.sv
// Highest-set-bit search, organised per word then across words.
module irq_prio_find #(
  parameter int N      = 256,
  parameter int WORD_W = 32,
  parameter int IW     = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  localparam int NWORDS = N / WORD_W;
  localparam int LOW_W  = $clog2(WORD_W);
  localparam int HI_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  function automatic logic [LOW_W-1:0] top_bit(input logic [WORD_W-1:0] w);
    logic [LOW_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++)
      if (w[b]) r = LOW_W'(b);
    return r;
  endfunction

  logic [NWORDS-1:0] word_any;
  logic [LOW_W-1:0]  lo_arr [NWORDS];
  logic [HI_W-1:0]   hi_sel;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign word_any[w] = |bits_i[w*WORD_W +: WORD_W];
    assign lo_arr[w]   = top_bit(bits_i[w*WORD_W +: WORD_W]);
  end

  always_comb begin
    hi_sel = '0;
    for (int w = 0; w < NWORDS; w++)
      if (word_any[w]) hi_sel = HI_W'(w);
  end

  assign any_o = |word_any;
  assign idx_o = IW'(int'(hi_sel) * WORD_W + int'(lo_arr[hi_sel]));
endmodule

// File: rtl/irq_prio_ppr.sv
// Processor priority from task priority and top in-service vector.
module irq_prio_ppr #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_top_i,
  output logic [VEC_W-1:0] ppr_o
);
  localparam int SUB_W = VEC_W - CLS_W;

  logic [VEC_W-1:0] isr_eff;
  logic [CLS_W-1:0] tpr_cls, isr_cls;

  assign isr_eff = isr_any_i ? isr_top_i : '0;
  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign isr_cls = isr_eff[VEC_W-1 -: CLS_W];
  assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {SUB_W{1'b0}}};
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = $clog2(NUM_VEC),
  parameter int CLS_W   = 4,
  parameter int WORD_W  = 32,
  parameter int WR_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_en_i,
  input  logic             sw_en_i,
  input  logic             acc_valid_i,
  input  logic [VEC_W-1:0] acc_vec_i,
  input  logic             acc_level_i,
  input  logic [2:0]       acc_kind_i,
  input  logic             tpr_we_i,
  input  logic [WR_W-1:0]  tpr_wdata_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             eoi_bc_o,
  output logic [VEC_W-1:0] eoi_bc_vec_o
);
  localparam int SUB_W = VEC_W - CLS_W;

  logic [NUM_VEC-1:0] pend_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] pend_a, tmr_a, isr_m, pend_n, isr_n, tmr_n;
  logic [VEC_W-1:0]   tpr_q;
  logic               irq_req_q, eoi_bc_q;
  logic [VEC_W-1:0]   irq_vec_q, ppr_q, eoi_bc_vec_q;

  logic               unit_en, acc_take, ack_take, eoi_take, bc_fire, offer;
  logic               pend_any, isr_any, eoi_any;
  logic [VEC_W-1:0]   pend_top, isr_top, eoi_top, ppr_cur;
  logic               tpr_hi_unused;

  assign tpr_hi_unused = |tpr_wdata_i[WR_W-1:VEC_W];

  assign unit_en  = glob_en_i & sw_en_i;
  assign acc_take = acc_valid_i & unit_en & kind_is_fixed_like(acc_kind_i)
                  & ~(acc_level_i & pend_q[acc_vec_i]);
  assign ack_take = ack_i & irq_req_q;

  irq_prio_find #(.N(NUM_VEC), .WORD_W(WORD_W), .IW(VEC_W)) u_find_pend (
    .bits_i(pend_q), .any_o(pend_any), .idx_o(pend_top));
  irq_prio_find #(.N(NUM_VEC), .WORD_W(WORD_W), .IW(VEC_W)) u_find_isr (
    .bits_i(isr_q), .any_o(isr_any), .idx_o(isr_top));
  irq_prio_find #(.N(NUM_VEC), .WORD_W(WORD_W), .IW(VEC_W)) u_find_eoi (
    .bits_i(isr_m), .any_o(eoi_any), .idx_o(eoi_top));

  irq_prio_ppr #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_top_i(isr_top), .ppr_o(ppr_cur));

  // Stage 1: accept
  always_comb begin
    pend_a = pend_q;
    tmr_a  = tmr_q;
    if (acc_take) begin
      pend_a[acc_vec_i] = 1'b1;
      tmr_a[acc_vec_i]  = acc_level_i;
    end
  end

  // Stage 2: acknowledge (moves the offered vector into service)
  always_comb begin
    isr_m = isr_q;
    if (ack_take) isr_m[irq_vec_q] = 1'b1;
  end

  assign eoi_take = eoi_i & eoi_any;
  assign bc_fire  = eoi_take & tmr_a[eoi_top];

  // Stage 3: end-of-interrupt on the post-acknowledge set
  always_comb begin
    pend_n = pend_a;
    isr_n  = isr_m;
    tmr_n  = tmr_a;
    if (ack_take) pend_n[irq_vec_q] = 1'b0;
    if (eoi_take) begin
      isr_n[eoi_top] = 1'b0;
      tmr_n[eoi_top] = 1'b0;
    end
  end

  assign offer = unit_en & pend_any
               & ({pend_top[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}} > ppr_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= '0;
      isr_q        <= '0;
      tmr_q        <= '0;
      tpr_q        <= '0;
      irq_req_q    <= 1'b0;
      irq_vec_q    <= '0;
      ppr_q        <= '0;
      eoi_bc_q     <= 1'b0;
      eoi_bc_vec_q <= '0;
    end else begin
      pend_q       <= pend_n;
      isr_q        <= isr_n;
      tmr_q        <= tmr_n;
      if (tpr_we_i) tpr_q <= tpr_wdata_i[VEC_W-1:0];
      irq_req_q    <= offer & ~ack_take;
      irq_vec_q    <= pend_top;
      ppr_q        <= ppr_cur;
      eoi_bc_q     <= bc_fire;
      eoi_bc_vec_q <= eoi_top;
    end
  end

  assign irq_req_o    = irq_req_q;
  assign irq_vec_o    = irq_vec_q;
  assign ppr_o        = ppr_q;
  assign eoi_bc_o     = eoi_bc_q;
  assign eoi_bc_vec_o = eoi_bc_vec_q;

  AST_OFF_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && !unit_en && !pend_q[acc_vec_i]) |=> !pend_q[$past(acc_vec_i)]); // R3
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req_q) |-> $past(unit_en)); // R4
  AST_REQ_ABOVE_PPR: assert property (@(posedge clk) disable iff (rst)
    irq_req_q |-> ({irq_vec_q[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}} > ppr_q)); // R5
  AST_ACK_MOVES_VEC: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !eoi_i) |=> (isr_q[$past(irq_vec_q)] && !pend_q[$past(irq_vec_q)])); // R7
  AST_EOI_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && (isr_q == '0) && !ack_take) |=> !eoi_bc_q); // R8
  AST_BC_CLEARS_TRIG: assert property (@(posedge clk) disable iff (rst)
    eoi_bc_q |-> (!tmr_q[eoi_bc_vec_q] && !isr_q[eoi_bc_vec_q])); // R10
endmodule

// File: tb/irq_prio_unit_test.sv
module irq_prio_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       glob_en = 1'b0, sw_en = 1'b0;
  logic       acc_valid = 1'b0, acc_level = 1'b0;
  logic [7:0] acc_vec = '0;
  logic [2:0] acc_kind = '0;
  logic       tpr_we = 1'b0;
  logic [31:0] tpr_wdata = '0;
  logic       ack = 1'b0, eoi = 1'b0;
  logic       irq_req, eoi_bc;
  logic [7:0] irq_vec, ppr, eoi_bc_vec;

  int checks = 0;
  int fails  = 0;
  int exp_bc[$];

  always #2 clk = ~clk;

  irq_prio_unit uut (
    .clk(clk), .rst(rst), .glob_en_i(glob_en), .sw_en_i(sw_en),
    .acc_valid_i(acc_valid), .acc_vec_i(acc_vec), .acc_level_i(acc_level),
    .acc_kind_i(acc_kind), .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata),
    .ack_i(ack), .eoi_i(eoi), .irq_req_o(irq_req), .irq_vec_o(irq_vec),
    .ppr_o(ppr), .eoi_bc_o(eoi_bc), .eoi_bc_vec_o(eoi_bc_vec));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: every broadcast pops the scoreboard (R10)
  always @(negedge clk) begin
    if (!rst && eoi_bc) begin
      checks++;
      if (exp_bc.size() == 0) begin
        fails++;
        $display("FAIL R10 broadcast: actual 0x%0h expected none", eoi_bc_vec);
      end else begin
        int e;
        e = exp_bc.pop_front();
        if (int'(eoi_bc_vec) != e) begin
          fails++;
          $display("FAIL R10 broadcast vector: actual 0x%0h expected 0x%0h", eoi_bc_vec, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; ack = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
  endtask

  task automatic accept(input int v, input bit lvl, input int kind);
    acc_valid = 1'b1; acc_vec = 8'(v); acc_level = lvl; acc_kind = 3'(kind);
    step(); step();
  endtask

  task automatic write_tpr(input int val);
    tpr_we = 1'b1; tpr_wdata = 32'(val);
    step(); step();
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    chk("R7", "request in cycle after acknowledge", irq_req, 0);
    step();
  endtask

  task automatic do_eoi(input bit bc, input int v);
    if (bc) exp_bc.push_back(v);
    eoi = 1'b1;
    step(); step();
  endtask

  task automatic outs(input string tag, input bit req, input int vec, input int pp);
    chk(tag, "irq_req", irq_req, req);
    if (req) chk(tag, "irq_vec", irq_vec, vec);
    chk(tag, "ppr", ppr, pp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    outs("R1", 0, 0, 0);
    chk("R1", "eoi_bc", eoi_bc, 0);

    // R3 requests dropped while either enable is low
    glob_en = 1'b1; sw_en = 1'b0;
    accept(8'h50, 0, 0);
    glob_en = 1'b0; sw_en = 1'b1;
    accept(8'h51, 0, 0);
    glob_en = 1'b1;
    step(); step();
    outs("R3", 0, 0, 0);

    // R4 offer of a pending fixed vector
    accept(8'h45, 0, 0);
    outs("R4", 1, 8'h45, 0);
    sw_en = 1'b0; step(); step();
    chk("R4", "irq_req with software enable low", irq_req, 0);
    sw_en = 1'b1; glob_en = 1'b0; step(); step();
    chk("R4", "irq_req with global enable low", irq_req, 0);
    glob_en = 1'b1; step(); step();
    outs("R4", 1, 8'h45, 0);

    // R2 delivery kinds
    accept(8'h80, 0, 4);
    outs("R2", 1, 8'h45, 0);
    accept(8'h62, 0, 1);
    outs("R2", 1, 8'h62, 0);
    accept(8'hF0, 0, 7);
    outs("R2", 1, 8'h62, 0);

    // R6 truncation, R4 strict comparison boundaries
    write_tpr(32'h0000_0365);
    outs("R6", 0, 0, 8'h65);
    ack = 1'b1; step(); step();          // R7 acknowledge with nothing offered
    chk("R7", "irq_req after ignored acknowledge", irq_req, 0);
    write_tpr(8'h5F);
    outs("R4", 1, 8'h62, 8'h5F);         // R7 pending survived ignored acknowledge
    write_tpr(8'h60);
    outs("R4", 0, 0, 8'h60);             // equal class is not eligible
    write_tpr(8'h00);
    outs("R4", 1, 8'h62, 0);

    // R7 acknowledge, R5 priority from in-service
    do_ack();
    outs("R5", 0, 0, 8'h60);
    write_tpr(8'h7A);
    outs("R5", 0, 0, 8'h7A);
    write_tpr(8'h00);
    outs("R5", 0, 0, 8'h60);

    // R9 level request, R10 broadcast on retire
    accept(8'h93, 1, 0);
    outs("R9", 1, 8'h93, 8'h60);
    do_ack();
    outs("R5", 0, 0, 8'h90);
    do_eoi(1, 8'h93);
    outs("R8", 0, 0, 8'h60);
    do_eoi(0, 0);
    outs("R8", 1, 8'h45, 0);
    do_eoi(0, 0);                        // empty in-service set
    outs("R8", 1, 8'h45, 0);

    // R9 level duplicate of an edge vector is dropped: no broadcast later
    accept(8'hB0, 0, 0);
    accept(8'hB0, 1, 0);
    outs("R9", 1, 8'hB0, 0);
    do_ack();
    outs("R9", 0, 0, 8'hB0);
    do_eoi(0, 0);
    outs("R9", 1, 8'h45, 0);
    // R9 edge request after a level one clears the trigger bit
    accept(8'hC1, 1, 0);
    accept(8'hC1, 0, 0);
    do_ack();
    do_eoi(0, 0);
    outs("R9", 1, 8'h45, 0);

    // R11 accept, acknowledge and end-of-interrupt in one cycle
    accept(8'hD7, 1, 0);
    outs("R11", 1, 8'hD7, 0);
    acc_valid = 1'b1; acc_vec = 8'hE8; acc_level = 1'b1; acc_kind = 3'd0;
    ack = 1'b1; eoi = 1'b1;
    exp_bc.push_back(8'hD7);
    step();
    chk("R11", "irq_req after combined cycle", irq_req, 0);
    step();
    outs("R11", 1, 8'hE8, 0);
    do_ack();
    do_eoi(1, 8'hE8);
    outs("R10", 1, 8'h45, 0);

    do_ack();
    do_eoi(0, 0);
    outs("R8", 0, 0, 0);
    step();

    checks++;
    if (exp_bc.size() != 0) begin
      fails++;
      $display("FAIL R10 missing broadcasts: actual %0d left expected 0", exp_bc.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule